// File: doc/BRIEF.md
# Triggered DMA Request Generator Channel

One channel of a hardware DMA request source. It watches a bus of trigger lines, picks one of them through a select field, and waits for an edge of the chosen kind on that line. The edge counts only once the new level has been seen for long enough. A qualified edge starts a burst: the channel raises a request, the DMA controller serves it with a one-cycle pulse, and the channel raises the next request. After a programmed count plus one requests the channel falls silent until the next qualified edge.

Settings come from a control word that the channel captures on a write strobe. Every write blanks trigger detection for a short window. A qualified edge that arrives while a burst is still running sets a sticky overrun flag and leaves the burst untouched. The flag drives an interrupt output when its enable bit is set. Trigger lines are taken to be synchronous to `clk`. The request and served pins form a simple request/acknowledge pair, so the block has no stream port. The served pulse is the only back-pressure the channel sees: a request stays up for as many cycles as the controller takes to serve it.

Top module: `trig_req_gen`

## Requirements
- R1: Only the trigger line whose index equals the captured select field can start a burst; activity on every other line of `trig_i` has no effect on `dreq_o`.
- R2: The captured 2-bit polarity field selects the active edge. 00 selects no edge, 01 a rising edge (0 to 1), 10 a falling edge (1 to 0) and 11 both.
- R3: An edge is qualified only when the selected line shows its new level at three consecutive rising clock edges. A level that lasts for fewer samples is ignored and does not change the stored line level.
- R4: A qualified edge is discarded when its third matching sample falls on any of the three clock edges that follow the edge which captured a `cfg_wr_i` write. An edge whose third sample comes four edges after the write is accepted.
- R5: A qualified edge that arrives while the channel is enabled and idle produces exactly `cnt`+1 requests, where `cnt` is the captured count field. While the channel is disabled, edges produce no requests.
- R6: `dreq_o` stays high until a `served_i` pulse. It is low in the cycle after that pulse, and it is high again one cycle later if requests of the burst remain.
- R7: A qualified edge that arrives while the channel is enabled and a burst is in progress sets the overrun flag. It neither restarts nor extends the burst.
- R8: The overrun flag stays set until a `ovr_clr_i` pulse clears it. If a set and a clear land on the same edge, the set wins.
- R9: `irq_o` is high exactly while the overrun flag is set and the captured interrupt enable bit is 1.
- R10: A write that clears the enable bit drops `dreq_o` right after the edge that captures it and aborts the burst. After the channel is enabled again, the next qualified edge starts a full burst.
- R11: After reset, `dreq_o`, `ovr_o` and `irq_o` are low and the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | NUM_TRIG | Trigger line bus, synchronous to clk |
| cfg_wr_i | input | 1 | Control word write strobe |
| cfg_en_i | input | 1 | Channel enable |
| cfg_sel_i | input | SEL_W | Trigger line index |
| cfg_pol_i | input | 2 | Active edge: 00 none, 01 rise, 10 fall, 11 both |
| cfg_cnt_i | input | CNT_W | Requests per burst minus one |
| cfg_ovie_i | input | 1 | Overrun interrupt enable |
| served_i | input | 1 | One-cycle pulse when the DMA serves the request |
| ovr_clr_i | input | 1 | Clear pulse for the overrun flag |
| dreq_o | output | 1 | DMA request |
| ovr_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Overrun interrupt |

## Verification
Some properties are checked on every cycle: a detected event is a single pulse, no event comes out during the write blanking window, a disable returns the burst to idle, the low request cycle after a serve and the final serve returning the channel to idle, and the overrun flag's stickiness and setting. Other behaviour can only be shown by the bench's scenarios: the exact request count per burst under random counts, lines, polarities and serve delays, the rejection of short glitches and of unselected lines, the four-edge boundary of the blanking window, an overrun that leaves the burst length unchanged, and a full restart after an abort.

// File: rtl/trg_pkg.sv
package trg_pkg;
  typedef enum logic [1:0] {
    POL_NONE = 2'b00,
    POL_RISE = 2'b01,
    POL_FALL = 2'b10,
    POL_BOTH = 2'b11
  } pol_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2
  } bst_e;
endpackage

// File: rtl/trg_edge_qual.sv
module trg_edge_qual
  import trg_pkg::*;
#(
  parameter int NUM_TRIG = 8,
  parameter int FILT_LEN = 3,
  parameter int MASK_LEN = 3,
  localparam int SEL_W = $clog2(NUM_TRIG),
  localparam int DC_W  = $clog2(FILT_LEN + 1),
  localparam int MK_W  = $clog2(MASK_LEN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                wr_i,
  input  logic [SEL_W-1:0]    wr_sel_i,
  input  pol_e                pol_i,
  output logic                evt_o
);
  logic            lvl, new_lvl, flt_q, evt_q, edge_ok;
  logic [DC_W-1:0] dc_q;
  logic [MK_W-1:0] mask_q;

  assign lvl     = trig_i[sel_i];
  assign new_lvl = trig_i[wr_sel_i];
  // bit 0 of the polarity enables rising edges, bit 1 falling edges
  assign edge_ok = lvl ? pol_i[0] : pol_i[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q  <= 1'b0;
      dc_q   <= '0;
      mask_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (wr_i)              mask_q <= MK_W'(MASK_LEN);
      else if (mask_q != '0) mask_q <= mask_q - 1'b1;

      if (wr_i && (wr_sel_i != sel_i)) begin
        flt_q <= new_lvl;
        dc_q  <= '0;
      end else if (lvl == flt_q) begin
        dc_q <= '0;
      end else if (dc_q == DC_W'(FILT_LEN - 1)) begin
        flt_q <= lvl;
        dc_q  <= '0;
        evt_q <= (mask_q == '0) && edge_ok;
      end else begin
        dc_q <= dc_q + 1'b1;
      end
    end
  end

  assign evt_o = evt_q;

  // R3
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> !evt_q);
  // R4
  wr_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ##1 !evt_q);
endmodule

// File: rtl/trg_burst_ctl.sv
module trg_burst_ctl
  import trg_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             served_i,
  output logic             req_o,
  output logic             ovr_evt_o
);
  bst_e             st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (!en_i) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (evt_i) begin
          cnt_q <= cnt_i;
          st_q  <= ST_REQ;
        end
        ST_REQ: if (served_i) begin
          if (cnt_q == '0) st_q <= ST_IDLE;
          else begin
            cnt_q <= cnt_q - 1'b1;
            st_q  <= ST_GAP;
          end
        end
        ST_GAP:  st_q <= ST_REQ;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o     = (st_q == ST_REQ) && en_i;
  assign ovr_evt_o = evt_i && en_i && (st_q != ST_IDLE);

  // R10
  dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (st_q == ST_IDLE));
  // R6
  gap_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP && en_i) |=> (st_q == ST_REQ));
  // R6
  serve_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REQ && served_i) |=> (st_q != ST_REQ));
  // R5
  last_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REQ && served_i && cnt_q == '0) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/trig_req_gen.sv
module trig_req_gen
  import trg_pkg::*;
#(
  parameter int NUM_TRIG = 8,
  parameter int CNT_W    = 5,
  localparam int SEL_W   = $clog2(NUM_TRIG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic                cfg_wr_i,
  input  logic                cfg_en_i,
  input  logic [SEL_W-1:0]    cfg_sel_i,
  input  logic [1:0]          cfg_pol_i,
  input  logic [CNT_W-1:0]    cfg_cnt_i,
  input  logic                cfg_ovie_i,
  input  logic                served_i,
  input  logic                ovr_clr_i,
  output logic                dreq_o,
  output logic                ovr_o,
  output logic                irq_o
);
  logic             en_q, ovie_q, ovr_q, evt, ovr_set;
  logic [SEL_W-1:0] sel_q;
  pol_e             pol_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      pol_q  <= POL_NONE;
      cnt_q  <= '0;
      ovie_q <= 1'b0;
    end else if (cfg_wr_i) begin
      en_q   <= cfg_en_i;
      sel_q  <= cfg_sel_i;
      pol_q  <= pol_e'(cfg_pol_i);
      cnt_q  <= cfg_cnt_i;
      ovie_q <= cfg_ovie_i;
    end
  end

  trg_edge_qual #(.NUM_TRIG(NUM_TRIG)) qual_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (trig_i),
    .sel_i   (sel_q),
    .wr_i    (cfg_wr_i),
    .wr_sel_i(cfg_sel_i),
    .pol_i   (pol_q),
    .evt_o   (evt)
  );

  trg_burst_ctl #(.CNT_W(CNT_W)) ctl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_q),
    .evt_i    (evt),
    .cnt_i    (cnt_q),
    .served_i (served_i),
    .req_o    (dreq_o),
    .ovr_evt_o(ovr_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovr_q <= 1'b0;
    else if (ovr_set)   ovr_q <= 1'b1;
    else if (ovr_clr_i) ovr_q <= 1'b0;
  end

  assign ovr_o = ovr_q;
  assign irq_o = ovr_q && ovie_q;

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr_i) |=> ovr_q);
  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> ovr_q);
  // R8
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr_i && !ovr_set) |=> !ovr_q);
endmodule

// File: tb/trig_req_gen_tb_top.sv
module trig_req_gen_tb_top;
  localparam int NT = 8;
  localparam int CW = 5;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NT-1:0] lv = '0;
  logic          wr = 0, en = 0, ovie = 0, served = 0, clr = 0;
  logic [2:0]    sel = 0;
  logic [1:0]    pol = 0;
  logic [CW-1:0] cnt = 0;
  logic          dreq_o, ovr_o, irq_o;
  int            n_run = 0, n_fail = 0, gap_err = 0;
  bit            timeout = 0;

  always #10 clk = ~clk;

  trig_req_gen #(.NUM_TRIG(NT), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(lv), .cfg_wr_i(wr), .cfg_en_i(en),
    .cfg_sel_i(sel), .cfg_pol_i(pol), .cfg_cnt_i(cnt), .cfg_ovie_i(ovie),
    .served_i(served), .ovr_clr_i(clr), .dreq_o(dreq_o), .ovr_o(ovr_o),
    .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_reqs(input logic [1:0] p, input logic nv, input int c);
    bit hit = nv ? p[0] : p[1];
    return hit ? c + 1 : 0;
  endfunction

  task automatic cfg(input logic e, input int s, input logic [1:0] p, input int c, input logic ie);
    @(negedge clk);
    wr = 1; en = e; sel = 3'(s); pol = p; cnt = CW'(c); ovie = ie;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // acts as the DMA controller until the request stays low for 12 cycles
  task automatic run_burst(input int expn, output int n);
    int quiet = 0;
    n = 0;
    while (quiet < 12 && n < 64) begin
      @(negedge clk);
      if (dreq_o) begin
        quiet = 0;
        repeat ($urandom % 3) @(negedge clk);
        served = 1;
        @(negedge clk);
        served = 0;
        n++;
        if (dreq_o) gap_err++;
        @(negedge clk);
        if (n < expn && !dreq_o) gap_err++;
        if (dreq_o) quiet = 0; else quiet = 1;
      end else quiet++;
    end
  endtask

  task automatic main();
    int n, e;
    void'($urandom(32'd20240611));
    idle(3);
    chk(!dreq_o && !ovr_o && !irq_o, "R11 reset outputs", {dreq_o, ovr_o, irq_o}, 0);
    rst_n = 1;
    idle(2);
    // R5 disabled channel ignores edges
    cfg(0, 1, 2'b01, 2, 0); idle(4);
    lv[1] = 1; run_burst(0, n);
    chk(n == 0, "R5 disabled no requests", n, 0);
    lv[1] = 0; idle(6);
    // R5 R6 directed burst, rising, cnt=3
    gap_err = 0;
    cfg(1, 1, 2'b01, 3, 0); idle(6);
    lv[1] = 1; run_burst(4, n);
    chk(n == 4, "R5 burst count cnt+1", n, 4);
    chk(gap_err == 0, "R6 low cycle then re-raise", gap_err, 0);
    // R2 falling edge with rising polarity
    lv[1] = 0; run_burst(0, n);
    chk(n == 0, "R2 fall ignored by rise polarity", n, 0);
    // R1 unselected line
    lv[5] = 1; run_burst(0, n);
    chk(n == 0, "R1 unselected line ignored", n, 0);
    lv[5] = 0; idle(4);
    // R3 two-sample glitch
    @(negedge clk); lv[1] = 1; idle(2); lv[1] = 0;
    run_burst(0, n);
    chk(n == 0, "R3 short glitch ignored", n, 0);
    // R3 three samples suffice
    @(negedge clk); lv[1] = 1; idle(3); lv[1] = 0;
    run_burst(4, n);
    chk(n == 4, "R3 three-sample pulse accepted", n, 4);
    // R2 polarity none
    cfg(1, 1, 2'b00, 1, 0); idle(6);
    lv[1] = 1; run_burst(0, n);
    chk(n == 0, "R2 polarity 00 no event", n, 0);
    lv[1] = 0; idle(6);
    // R4 blanking: third sample at write edge + 1
    cfg(1, 2, 2'b01, 1, 0); idle(6);
    @(negedge clk); lv[2] = 1;
    @(negedge clk); wr = 1;
    @(negedge clk); wr = 0;
    run_burst(0, n);
    chk(n == 0, "R4 edge inside blank window", n, 0);
    // R4 third sample at write edge + 3: blanked
    lv[2] = 0; idle(6);
    @(negedge clk); wr = 1;
    @(negedge clk); wr = 0; lv[2] = 1;
    run_burst(0, n);
    chk(n == 0, "R4 edge at window end blanked", n, 0);
    // R4 third sample at write edge + 4: accepted
    lv[2] = 0; idle(6);
    @(negedge clk); wr = 1;
    @(negedge clk); wr = 0;
    @(negedge clk); lv[2] = 1;
    run_burst(2, n);
    chk(n == 2, "R4 edge after window accepted", n, 2);
    lv[2] = 0; idle(6);
    // R7 R9 overrun during burst, both edges
    cfg(1, 3, 2'b11, 5, 1); idle(6);
    lv[3] = 1;
    fork
      run_burst(6, n);
      begin idle(9); lv[3] = 0; end
    join
    chk(n == 6, "R7 overrun leaves burst length", n, 6);
    chk(ovr_o == 1, "R7 overrun flag set", ovr_o, 1);
    chk(irq_o == 1, "R9 irq with enable", irq_o, 1);
    idle(5);
    chk(ovr_o == 1, "R8 flag stays set", ovr_o, 1);
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    chk(ovr_o == 0 && irq_o == 0, "R8 clear pulse", {ovr_o, irq_o}, 0);
    // R9 flag without interrupt enable
    cfg(1, 3, 2'b11, 5, 0); idle(6);
    lv[3] = 1;
    fork
      run_burst(6, n);
      begin idle(9); lv[3] = 0; end
    join
    chk(ovr_o == 1 && irq_o == 0, "R9 irq masked", {ovr_o, irq_o}, 2);
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    // R10 abort mid burst
    cfg(1, 4, 2'b01, 7, 0); idle(6);
    lv[4] = 1;
    begin
      int w = 0;
      while (!dreq_o && w < 20) begin @(negedge clk); w++; end
    end
    chk(dreq_o == 1, "R10 burst started", dreq_o, 1);
    cfg(0, 4, 2'b01, 7, 0);
    chk(dreq_o == 0, "R10 request drops on disable", dreq_o, 0);
    run_burst(0, n);
    chk(n == 0, "R10 stays idle after abort", n, 0);
    lv[4] = 0;
    cfg(1, 4, 2'b01, 2, 0); idle(6);
    lv[4] = 1; run_burst(3, n);
    chk(n == 3, "R10 full burst after re-enable", n, 3);
    // random mix: R1 R2 R5
    for (int it = 0; it < 24; it++) begin
      int s = $urandom % NT;
      int o = $urandom % NT;
      logic [1:0] p = 2'($urandom % 4);
      int c = $urandom % 6;
      logic nv;
      gap_err = 0;
      cfg(1, s, p, c, 0); idle(6);
      nv = ~lv[s];
      e = exp_reqs(p, nv, c);
      lv[s] = nv;
      if (o != s) lv[o] = ~lv[o];
      run_burst(e, n);
      chk(n == e, "R5 random burst count", n, e);
      chk(gap_err == 0, "R6 random serve gaps", gap_err, 0);
      chk(ovr_o == 0, "R7 no overrun when idle", ovr_o, 0);
    end
  endtask

  initial begin
    fork
      main();
      begin repeat (150000) @(posedge clk); timeout = 1; end
    join_any
    if (timeout) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule